// File: doc/BRIEF.md
# Class B Bus-Error Trap Detector

This block sits beside the operand and fetch ports of a small 16-bit CPU pipeline and watches every access that the pipeline starts. It detects two faults. The first is a word-sized operand read or write to an odd byte address. The second is any external fetch, read or write that starts while no external bus configuration is enabled. When either fault is seen, the block suppresses the access in the same cycle, records the fault in a sticky flag bit and raises a class B trap request. It also captures the return address that the sequencer must push, which is the address of the instruction after the faulting one.

The trap is precise for every kind of access, including write-only external accesses and memory-to-memory moves through two pointer registers. In the cycle of the fault, and for as long as the request is outstanding, the block drives a hold output that tells the sequencer to issue nothing further. That includes the linear successor, injected interrupts and software TRAP instructions. The request stays up until the sequencer acknowledges it. Software clears the flags with a per-bit strobe. A faulting access is always retired in the cycle it is presented, so a second bus fault inside the trap handler raises a new trap and never waits for a bus cycle that will not happen.

Top module: `bus_trap_detect`

## Requirements
- R1: A valid operand access (acc_kind 2'b01 read or 2'b10 write) with acc_word=1 and acc_addr[0]=1 sets flag_q[0] and raises trap_req. An instruction fetch (acc_kind 2'b00) never sets flag_q[0].
- R2: A byte access (acc_word=0) never sets flag_q[0] and raises no trap, whatever its address.
- R3: A valid access of any kind with acc_ext=1 while ext_cfg_en=0 sets flag_q[1] and raises trap_req. This includes write-only accesses. With ext_cfg_en=1 or acc_ext=0, flag_q[1] is not set.
- R4: trap_req is high in the cycle after a fault is detected. It stays high until a cycle in which trap_ack is high, and then falls on the next edge unless a new fault is detected in that same cycle.
- R5: trap_ip is loaded with acc_next_ip of the faulting access. While a request is pending and not acknowledged, trap_ip does not change, even if another fault occurs.
- R6: issue_hold is high in the fault cycle itself and in every cycle in which trap_req is high. Otherwise it is low.
- R7: If both faults occur in one access, both flag bits are set and a single trap request is raised.
- R8: The flag bits are sticky across trap_ack. flag_clr[i]=1 clears flag_q[i] on the next edge. A new fault in the same cycle wins over the clear.
- R9: A faulting access asserts acc_squash in the same cycle, with no wait state. A fault that arrives while the flags are still set, or in the cycle of trap_ack, raises a fresh request carrying the new return address.
- R10: After reset, flag_q=0, trap_req=0 and trap_ip=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access starts this cycle |
| acc_kind | input | 2 | 00 fetch, 01 read, 10 write |
| acc_word | input | 1 | 1 for a word access, 0 for a byte access |
| acc_addr | input | AW | Byte address of the access |
| acc_ext | input | 1 | Access targets the external bus |
| ext_cfg_en | input | 1 | An external bus configuration is enabled |
| acc_next_ip | input | AW | Address of the instruction after the one issuing the access |
| acc_squash | output | 1 | The access is faulting and must not be performed |
| issue_hold | output | 1 | The sequencer must issue no instruction or injected event |
| trap_req | output | 1 | Class B trap request |
| trap_ack | input | 1 | The sequencer takes the trap |
| trap_ip | output | AW | Return address to push |
| flag_clr | input | 2 | Per-bit clear strobe for flag_q |
| flag_q | output | 2 | Sticky flags: bit 0 odd operand, bit 1 disabled bus |

## Verification
A wrongly held pending state shows up at the ports at once. A stuck request keeps issue_hold high and stalls the sequencer. A lost request lets the next instruction issue in the cycle after the fault. A trap_ip register that reloads while pending is seen as a changed return address in the first cycle after the second fault. Flag corruption is visible one edge after the access or the clear strobe. For that reason every check samples just after the edge that follows the stimulus, and checks the combinational squash and hold outputs within the stimulus cycle itself.

// File: rtl/bus_trap_detect.sv
module bus_trap_detect #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [1:0]    acc_kind,
  input  logic          acc_word,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_ext,
  input  logic          ext_cfg_en,
  input  logic [AW-1:0] acc_next_ip,
  output logic          acc_squash,
  output logic          issue_hold,
  output logic          trap_req,
  input  logic          trap_ack,
  output logic [AW-1:0] trap_ip,
  input  logic [1:0]    flag_clr,
  output logic [1:0]    flag_q
);
  localparam logic [1:0] KIND_FETCH = 2'b00;

  logic det_odd, det_bus, det_any, load_ip;

  assign det_odd    = acc_valid & (acc_kind != KIND_FETCH) & acc_word & acc_addr[0];
  assign det_bus    = acc_valid & acc_ext & ~ext_cfg_en;
  assign det_any    = det_odd | det_bus;
  assign load_ip    = det_any & (~trap_req | trap_ack);
  assign acc_squash = det_any;
  assign issue_hold = det_any | trap_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= '0;
      trap_req <= 1'b0;
      trap_ip  <= '0;
    end else begin
      flag_q   <= (flag_q & ~flag_clr) | {det_bus, det_odd};
      trap_req <= det_any | (trap_req & ~trap_ack);
      if (load_ip) trap_ip <= acc_next_ip;
    end
  end

  // R4
  req_follows_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_squash |=> trap_req);

  // R5
  req_hold_ip_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && !trap_ack |=> trap_req && $stable(trap_ip));

  // R1
  odd_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[0]) |-> $past(acc_valid && acc_addr[0] && acc_kind != KIND_FETCH));

  // R2
  odd_flag_word_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[0]) |-> $past(acc_word));

  // R3
  bus_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[1]) |-> $past(acc_valid && acc_ext && !ext_cfg_en));

  // R6
  hold_when_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> issue_hold);
endmodule

// File: tb/bus_trap_detect_tb.sv
`timescale 1ns/1ps
module bus_trap_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_kind = 2'b00;
  logic        acc_word = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        acc_ext = 1'b0;
  logic        ext_cfg_en = 1'b1;
  logic [15:0] acc_next_ip = '0;
  logic        acc_squash, issue_hold, trap_req;
  logic        trap_ack = 1'b0;
  logic [15:0] trap_ip;
  logic [1:0]  flag_clr = 2'b00;
  logic [1:0]  flag_q;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  bus_trap_detect #(.AW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_word(acc_word), .acc_addr(acc_addr), .acc_ext(acc_ext),
    .ext_cfg_en(ext_cfg_en), .acc_next_ip(acc_next_ip), .acc_squash(acc_squash),
    .issue_hold(issue_hold), .trap_req(trap_req), .trap_ack(trap_ack),
    .trap_ip(trap_ip), .flag_clr(flag_clr), .flag_q(flag_q));

  // {kind[2], word, addr[16], ext, cfg_en, exp_flags[2], exp_req}
  localparam int NV = 10;
  localparam logic [23:0] VEC [NV] = '{
    {2'b01, 1'b1, 16'h1001, 1'b0, 1'b1, 2'b01, 1'b1},
    {2'b10, 1'b1, 16'h2003, 1'b0, 1'b1, 2'b01, 1'b1},
    {2'b00, 1'b1, 16'h3001, 1'b0, 1'b1, 2'b00, 1'b0},
    {2'b01, 1'b0, 16'h1001, 1'b0, 1'b1, 2'b00, 1'b0},
    {2'b10, 1'b0, 16'h0123, 1'b1, 1'b1, 2'b00, 1'b0},
    {2'b00, 1'b1, 16'h0400, 1'b1, 1'b0, 2'b10, 1'b1},
    {2'b10, 1'b0, 16'h0501, 1'b1, 1'b0, 2'b10, 1'b1},
    {2'b01, 1'b1, 16'h0600, 1'b1, 1'b1, 2'b00, 1'b0},
    {2'b01, 1'b1, 16'h0701, 1'b1, 1'b0, 2'b11, 1'b1},
    {2'b01, 1'b1, 16'h0800, 1'b0, 1'b1, 2'b00, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic idle();
    acc_valid = 1'b0; trap_ack = 1'b0; flag_clr = 2'b00;
  endtask

  task automatic put(input logic [1:0] k, input logic w, input logic [15:0] a,
                     input logic e, input logic c, input logic [15:0] nip);
    acc_valid = 1'b1; acc_kind = k; acc_word = w; acc_addr = a;
    acc_ext = e; ext_cfg_en = c; acc_next_ip = nip;
  endtask

  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  task automatic cleanup();
    @(negedge clk); idle(); trap_ack = 1'b1; flag_clr = 2'b11;
    @(negedge clk); idle();
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(flag_q == 2'b00, "R10 flags after reset", flag_q, 0);
    chk(trap_req == 1'b0, "R10 trap_req after reset", trap_req, 0);
    chk(trap_ip == 16'h0, "R10 trap_ip after reset", trap_ip, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [15:0] nip;
      nip = 16'h4000 + 16'(i * 2);
      @(negedge clk);
      put(VEC[i][23:22], VEC[i][21], VEC[i][20:5], VEC[i][4], VEC[i][3], nip);
      #1;
      chk(acc_squash == VEC[i][0], $sformatf("R9 squash vec%0d", i), acc_squash, VEC[i][0]);
      chk(issue_hold == VEC[i][0], $sformatf("R6 hold vec%0d", i), issue_hold, VEC[i][0]);
      after_edge();
      chk(flag_q == VEC[i][2:1], $sformatf("R1 R2 R3 R7 flags vec%0d", i), flag_q, VEC[i][2:1]);
      chk(trap_req == VEC[i][0], $sformatf("R4 req vec%0d", i), trap_req, VEC[i][0]);
      if (VEC[i][0])
        chk(trap_ip == nip, $sformatf("R5 ip vec%0d", i), trap_ip, nip);
      cleanup();
    end

    // R4 R5 R6: pending request held, second fault does not move trap_ip
    @(negedge clk); put(2'b01, 1'b1, 16'h0011, 1'b0, 1'b1, 16'h5000);
    after_edge();
    chk(trap_req && trap_ip == 16'h5000, "R5 first ip", trap_ip, 16'h5000);
    @(negedge clk); idle();
    repeat (2) after_edge();
    chk(trap_req == 1'b1, "R4 req held without ack", trap_req, 1);
    chk(issue_hold == 1'b1, "R6 hold while pending", issue_hold, 1);
    @(negedge clk); put(2'b01, 1'b1, 16'h0100, 1'b1, 1'b0, 16'h6000);
    after_edge();
    chk(trap_ip == 16'h5000, "R5 ip kept on second fault", trap_ip, 16'h5000);
    chk(flag_q == 2'b11, "R3 second fault flag", flag_q, 2'b11);
    @(negedge clk); idle(); trap_ack = 1'b1;
    after_edge();
    chk(trap_req == 1'b0, "R4 req drops after ack", trap_req, 0);
    chk(issue_hold == 1'b0, "R6 hold low when idle", issue_hold, 0);
    chk(flag_q == 2'b11, "R8 flags sticky over ack", flag_q, 2'b11);

    // R8: per-bit clear, set wins
    @(negedge clk); idle(); flag_clr = 2'b01;
    after_edge();
    chk(flag_q == 2'b10, "R8 clear bit0 only", flag_q, 2'b10);
    @(negedge clk); idle(); flag_clr = 2'b01; flag_q_set_test();
    after_edge();
    chk(flag_q == 2'b11, "R8 set wins over clear", flag_q, 2'b11);
    chk(trap_req && trap_ip == 16'h7000, "R5 ip after set-wins fault", trap_ip, 16'h7000);

    // R9: fault in ack cycle, then fault inside handler with flags set
    @(negedge clk); idle(); trap_ack = 1'b1;
    put(2'b00, 1'b1, 16'h0200, 1'b1, 1'b0, 16'h8000);
    #1;
    chk(acc_squash == 1'b1, "R9 squash in ack cycle", acc_squash, 1);
    after_edge();
    chk(trap_req == 1'b1, "R9 req renewed on ack-cycle fault", trap_req, 1);
    chk(trap_ip == 16'h8000, "R9 ip renewed on ack-cycle fault", trap_ip, 16'h8000);
    @(negedge clk); idle(); trap_ack = 1'b1;
    after_edge();
    chk(trap_req == 1'b0, "R4 req drops", trap_req, 0);
    @(negedge clk); idle(); put(2'b01, 1'b1, 16'h0300, 1'b1, 1'b0, 16'h9000);
    #1;
    chk(acc_squash && issue_hold, "R9 nested fault squashed same cycle", acc_squash, 1);
    after_edge();
    chk(trap_req && trap_ip == 16'h9000, "R9 nested fault new trap", trap_ip, 16'h9000);
    cleanup();
    #1;
    chk(flag_q == 2'b00 && trap_req == 1'b0, "R8 all cleared", flag_q, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic flag_q_set_test();
    put(2'b10, 1'b1, 16'h0007, 1'b0, 1'b1, 16'h7000);
  endtask
endmodule